// File: doc/BRIEF.md
# Scratchpad Write and Status Unit

This unit takes the byte stream of a scratchpad write transaction, already assembled from the single-wire bit slots. That stream is a command byte, two target-address bytes and then up to eight data bytes. It loads an eight-byte scratchpad, holds the aligned target address and builds the end/status byte that a later read-back returns to the master.

Each data byte passes through a region filter before it is stored. The filter has two rules:
- When one-time-programmable emulation is enabled and the target lies in page 0x20–0x3F, the stored byte is the master's byte ANDed with the current memory byte.
- In the configuration page 0x88–0x8F, a location that already holds a locking code keeps its stored value.

The unit reads the memory byte at each target location through a combinational read port. After the eighth data byte, the master can clock out an inverted CRC-16 taken over everything it sent.

Top module: `scratchpad_write_unit`

## Requirements
- R1: After reset the status byte reads 0x7F (PF set, AA clear), both address outputs read 0x00, the scratchpad reads all zero, `en_load` is 0 and `rd_byte` is 0xFF.
- R2: A transaction whose raw 16-bit target address {second byte, first byte} is 0x0090 or higher is abandoned. It leaves the address, the flags and the scratchpad unchanged, and `rd_byte` stays 0xFF until the next bus reset.
- R3: An accepted address is stored with its low three bits forced to 000, and the status byte's bits 2..0 always read 111, whatever the number of data bytes sent.
- R4: The status byte is {AA, 1, PF, 1, 1, 1, 1, 1}: AA in bit 7, PF in bit 5, and bits 6, 4 and 3 always read 1.
- R5: An accepted address clears PF and AA. A bus reset arriving with `partial_in` high while fewer than eight data bytes of an accepted write have arrived sets PF, and the fragment is not stored.
- R6: Data byte k (k = 0..7) is stored in scratchpad offset k, which appears on `sp_data[8k+7:8k]`. The memory read port addresses {aligned target bits 7..3, k}.
- R7: With `otp_mode` high and a target in 0x20–0x3F, each stored byte is the master's byte ANDed with `mem_rdata`. With `otp_mode` low the master's byte is stored unchanged.
- R8: For a target in 0x88–0x8F, a data byte whose memory location holds 0xAA or 0x55 is stored as that memory value. Any other location stores the master's byte.
- R9: `en_load` is set by `en_load_set` and is cleared when the second address byte of a write command arrives. The clear wins if both happen in the same cycle.
- R10: After the eighth data byte, `rd_byte` shows the inverted CRC-16 (x^16+x^15+x^2+1, zero start, bits taken LSB first) over the command, the raw address bytes and the data as sent. The low byte is shown first, and each `rd_req` advances to the next byte. After the two CRC bytes, `rd_byte` reads 0xFF.
- R11: Data bytes after the eighth are ignored: the scratchpad and the CRC are unchanged.
- R12: A first byte other than 0x0F makes the unit ignore the rest of the transaction until a bus reset.
- R13: `aa_set` sets AA, unless an address is accepted in the same cycle, in which case the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| byte_valid | input | 1 | Strobe for one received byte |
| byte_data | input | 8 | Received byte |
| bus_reset | input | 1 | Bus reset / transaction abort |
| partial_in | input | 1 | With bus_reset: last byte was incomplete |
| rd_req | input | 1 | Master consumed one read byte |
| otp_mode | input | 1 | One-time-programmable emulation active for page 0x20–0x3F |
| en_load_set | input | 1 | Sets the enable-load flag |
| aa_set | input | 1 | Sets the authorization-accepted flag |
| mem_rdata | input | 8 | Memory byte at mem_addr (combinational) |
| mem_addr | output | 8 | Memory read address for the next data byte |
| ta1 | output | 8 | Aligned low target address |
| ta2 | output | 8 | High target address |
| es_byte | output | 8 | End/status byte |
| rd_byte | output | 8 | Byte returned on a master read |
| sp_data | output | 64 | Scratchpad, offset k at bits 8k+7:8k |
| en_load | output | 1 | Enable-load flag |

## Verification
The assertions take for granted three things about the inputs:
- `byte_valid` and `rd_req` are never high in the same cycle.
- `partial_in` carries meaning only alongside `bus_reset`.
- `mem_rdata` settles within the cycle from `mem_addr`.

The stimulus keeps to these rules. Bytes and read requests are issued one per cycle from separate tasks, a partial indication is raised only inside the bus-reset task, and the memory is modelled as a plain combinational array. `aa_set` is never pulsed in the cycle that completes an address, so the flag-rise checks see one cause at a time.

// File: rtl/scratchpad_write_unit.sv
module scratchpad_write_unit #(
  parameter logic [7:0]  WR_CMD     = 8'h0F,
  parameter logic [15:0] ADDR_LIMIT = 16'h0090
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        bus_reset,
  input  logic        partial_in,
  input  logic        rd_req,
  input  logic        otp_mode,
  input  logic        en_load_set,
  input  logic        aa_set,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_addr,
  output logic [7:0]  ta1,
  output logic [7:0]  ta2,
  output logic [7:0]  es_byte,
  output logic [7:0]  rd_byte,
  output logic [63:0] sp_data,
  output logic        en_load
);
  localparam int SP_BYTES = 8;
  localparam int IDX_W    = $clog2(SP_BYTES);

  typedef enum logic [2:0] {S_CMD, S_TA1, S_TA2, S_DATA, S_CRC, S_SKIP} st_t;

  st_t              st;
  logic [7:0]       ta1_q, ta2_q, ta1_raw;
  logic [IDX_W:0]   cnt;
  logic [1:0]       ridx;
  logic [15:0]      crc;
  logic             pf, aa, enl;
  logic [7:0]       sp [SP_BYTES];

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  wire        addr_ok = {byte_data, ta1_raw} < ADDR_LIMIT;
  wire        in_otp  = otp_mode && ta2_q == 8'h00 && ta1_q[7:5] == 3'b001;
  wire        in_cfg  = ta2_q == 8'h00 && ta1_q[7:3] == 5'b10001;
  wire        locked  = mem_rdata == 8'hAA || mem_rdata == 8'h55;
  wire [7:0]  wr_val  = (in_cfg && locked) ? mem_rdata :
                        in_otp ? (byte_data & mem_rdata) : byte_data;
  wire [15:0] crc_nx  = crc_step(crc, byte_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_CMD;
      ta1_q   <= '0;
      ta2_q   <= '0;
      ta1_raw <= '0;
      cnt     <= '0;
      ridx    <= '0;
      crc     <= '0;
      pf      <= 1'b1;
      aa      <= 1'b0;
      enl     <= 1'b0;
      for (int i = 0; i < SP_BYTES; i++) sp[i] <= '0;
    end else begin
      if (en_load_set) enl <= 1'b1;
      if (aa_set)      aa  <= 1'b1;
      if (bus_reset) begin
        if (partial_in && st == S_DATA) pf <= 1'b1;
        st <= S_CMD;
      end else if (byte_valid) begin
        case (st)
          S_CMD: begin
            crc <= crc_step(16'h0000, byte_data);
            st  <= (byte_data == WR_CMD) ? S_TA1 : S_SKIP;
          end
          S_TA1: begin
            ta1_raw <= byte_data;
            crc     <= crc_nx;
            st      <= S_TA2;
          end
          S_TA2: begin
            enl <= 1'b0;
            if (addr_ok) begin
              ta1_q <= {ta1_raw[7:IDX_W], {IDX_W{1'b0}}};
              ta2_q <= byte_data;
              pf    <= 1'b0;
              aa    <= 1'b0;
              cnt   <= '0;
              crc   <= crc_nx;
              st    <= S_DATA;
            end else begin
              st <= S_SKIP;
            end
          end
          S_DATA: begin
            sp[cnt[IDX_W-1:0]] <= wr_val;
            crc <= crc_nx;
            cnt <= cnt + 1'b1;
            if (cnt == SP_BYTES - 1) begin
              st   <= S_CRC;
              ridx <= '0;
            end
          end
          default: ;
        endcase
      end
      if (!bus_reset && rd_req && st == S_CRC && ridx != 2'd2) ridx <= ridx + 1'b1;
    end
  end

  assign mem_addr = {ta1_q[7:IDX_W], cnt[IDX_W-1:0]};
  assign ta1      = ta1_q;
  assign ta2      = ta2_q;
  assign en_load  = enl;
  assign es_byte  = {aa, 1'b1, pf, 2'b11, {IDX_W{1'b1}}};
  assign rd_byte  = (st != S_CRC) ? 8'hFF :
                    (ridx == 2'd0) ? ~crc[7:0] :
                    (ridx == 2'd1) ? ~crc[15:8] : 8'hFF;

  for (genvar k = 0; k < SP_BYTES; k++) begin : g_sp
    assign sp_data[8*k +: 8] = sp[k];
  end
endmodule

// File: rtl/scratchpad_write_unit_chk.sv
module scratchpad_write_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        bus_reset,
  input logic        partial_in,
  input logic        en_load_set,
  input logic        aa_set,
  input logic [7:0]  ta1,
  input logic [7:0]  ta2,
  input logic [7:0]  es_byte,
  input logic [63:0] sp_data,
  input logic        en_load
);
  // R5
  pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es_byte[5]) |-> $past(bus_reset && partial_in));

  // R5
  pf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(es_byte[5]) |-> $past(byte_valid && !bus_reset));

  // R13
  aa_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es_byte[7]) |-> $past(aa_set));

  // R9
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_load) |-> $past(en_load_set));

  // R9
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_load) |-> $past(byte_valid && !bus_reset));

  // R11
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_data) |-> $past(byte_valid && !bus_reset));

  // R2
  ta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ta2, ta1}) |-> $past(byte_valid && !bus_reset));
endmodule

bind scratchpad_write_unit scratchpad_write_unit_chk u_chk (.*);

// File: tb/scratchpad_write_unit_tb.sv
`timescale 1ns/1ps
module scratchpad_write_unit_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic byte_valid = 0, bus_reset = 0, partial_in = 0, rd_req = 0;
  logic otp_mode = 0, en_load_set = 0, aa_set = 0;
  logic [7:0] byte_data = 0;
  logic [7:0] mem_rdata, mem_addr, ta1, ta2, es_byte, rd_byte;
  logic [63:0] sp_data;
  logic en_load;

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr];

  scratchpad_write_unit u_dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] q [$];
  bit good, ok, m_pf, m_aa, m_en;
  logic [7:0] m_ta1, m_ta2;
  logic [7:0] m_sp [8];
  int m_ridx, n, k;
  logic [7:0] a, v;

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'h0;
    for (int j = 0; j < 11; j++)
      for (int b = 0; b < 8; b++) begin
        bit x = c[0] ^ q[j][b];
        c = c >> 1;
        if (x) c = c ^ 16'hA001;
      end
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); good = 0; ok = 0; m_pf = 1; m_aa = 0; m_en = 0;
      m_ta1 = 0; m_ta2 = 0; m_ridx = 0;
      for (int i = 0; i < 8; i++) m_sp[i] = 0;
    end else begin
      if (en_load_set) m_en = 1;
      if (aa_set) m_aa = 1;
      if (bus_reset) begin
        if (partial_in && ok && q.size() >= 3 && q.size() <= 10) m_pf = 1;
        q.delete(); good = 0; ok = 0;
      end else begin
        if (byte_valid) begin
          q.push_back(byte_data);
          n = q.size();
          if (n == 1) good = (byte_data == 8'h0F);
          else if (n == 3 && good) begin
            m_en = 0;
            if ({q[2], q[1]} < 16'h0090) begin
              ok = 1; m_ta1 = q[1] & 8'hF8; m_ta2 = q[2];
              m_pf = 0; m_aa = 0; m_ridx = 0;
            end
          end else if (n >= 4 && n <= 11 && ok) begin
            k = n - 4;
            a = m_ta1 + 8'(k);
            v = byte_data;
            if (otp_mode && a >= 8'h20 && a <= 8'h3F) v = byte_data & mem[a];
            if (a >= 8'h88 && a <= 8'h8F && (mem[a] == 8'hAA || mem[a] == 8'h55)) v = mem[a];
            m_sp[k] = v;
          end
        end
        if (rd_req && ok && q.size() >= 11) m_ridx++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [7:0] exp_rd;
  logic [15:0] cc;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_rd = 8'hFF;
      if (ok && q.size() >= 11) begin
        cc = ref_crc();
        exp_rd = (m_ridx == 0) ? ~cc[7:0] : (m_ridx == 1) ? ~cc[15:8] : 8'hFF;
      end
      chk("R3 ta1", {56'h0, ta1}, {56'h0, m_ta1});
      chk("R2 ta2", {56'h0, ta2}, {56'h0, m_ta2});
      chk("R4 es_byte", {56'h0, es_byte}, {56'h0, m_aa, 1'b1, m_pf, 5'b11111});
      chk("R6 sp_data", sp_data, {m_sp[7], m_sp[6], m_sp[5], m_sp[4], m_sp[3], m_sp[2], m_sp[1], m_sp[0]});
      chk("R9 en_load", {63'h0, en_load}, {63'h0, m_en});
      chk("R10 rd_byte", {56'h0, rd_byte}, {56'h0, exp_rd});
    end
  end

  task automatic send(input logic [7:0] b);
    byte_valid = 1; byte_data = b;
    @(negedge clk);
    byte_valid = 0;
  endtask

  task automatic brst(input logic p);
    bus_reset = 1; partial_in = p;
    @(negedge clk);
    bus_reset = 0; partial_in = 0;
  endtask

  task automatic rd();
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] t1, input logic [7:0] t2,
                    input int nb, input logic [7:0] base);
    send(c); send(t1); send(t2);
    for (int i = 0; i < nb; i++) send(base + 8'(i * 17));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 32; i < 40; i++) mem[i] = 8'h3C;
    mem[8'h88] = 8'hAA; mem[8'h89] = 8'h12; mem[8'h8A] = 8'h55; mem[8'h8B] = 8'h00;
    mem[8'h8C] = 8'h55; mem[8'h8D] = 8'hA5; mem[8'h8E] = 8'hAA; mem[8'h8F] = 8'h01;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 reset es", {56'h0, es_byte}, 64'h7F);
    chk("R1 reset ta", {48'h0, ta2, ta1}, 64'h0);
    chk("R1 reset sp", sp_data, 64'h0);
    chk("R1 reset rd", {56'h0, rd_byte}, 64'hFF);

    // R10: plain write, then CRC bytes and trailing FF
    wr(8'h0F, 8'h05, 8'h00, 8, 8'h11);
    chk("R3 aligned ta1", {56'h0, ta1}, 64'h00);
    rd(); rd(); rd(); rd();
    chk("R10 after CRC", {56'h0, rd_byte}, 64'hFF);
    brst(0);

    // R7: OTP AND-merge
    otp_mode = 1;
    wr(8'h0F, 8'h23, 8'h00, 8, 8'hF0);
    chk("R7 and-merge", {56'h0, sp_data[7:0]}, 64'h30);
    chk("R3 ta1 0x20", {56'h0, ta1}, 64'h20);
    brst(0);
    otp_mode = 0;
    wr(8'h0F, 8'h20, 8'h00, 8, 8'hF0);
    chk("R7 otp off", {56'h0, sp_data[7:0]}, 64'hF0);
    brst(0);

    // R8: locked bytes in configuration page
    wr(8'h0F, 8'h8F, 8'h00, 8, 8'h77);
    chk("R8 locked subst", {40'h0, sp_data[23:0]}, {40'h0, 8'h55, 8'h88, 8'hAA});
    rd(); rd();
    brst(0);

    // R2: addresses at and beyond the limit
    wr(8'h0F, 8'h90, 8'h00, 8, 8'h01);
    chk("R2 abandon ta", {48'h0, ta2, ta1}, 64'h0088);
    chk("R2 abandon rd", {56'h0, rd_byte}, 64'hFF);
    brst(1);
    wr(8'h0F, 8'h00, 8'h01, 3, 8'h01);
    chk("R2 abandon hi", {48'h0, ta2, ta1}, 64'h0088);
    brst(0);

    // R13 and R5: AA set, then cleared by accepted address
    aa_set = 1; @(negedge clk); aa_set = 0;
    chk("R13 aa set", {56'h0, es_byte}, 64'hDF);
    wr(8'h0F, 8'h48, 8'h00, 2, 8'h01);
    chk("R5 aa cleared", {56'h0, es_byte}, 64'h5F);
    brst(1);
    chk("R5 partial pf", {56'h0, es_byte}, 64'h7F);

    // R12: wrong command
    wr(8'h33, 8'h00, 8'h00, 8, 8'hC0);
    chk("R12 ignored", {56'h0, sp_data[7:0]}, 64'h01);
    brst(0);

    // R9: enable-load clear after second address byte
    en_load_set = 1; @(negedge clk); en_load_set = 0;
    send(8'h0F); send(8'h60);
    chk("R9 still set", {63'h0, en_load}, 64'h1);
    send(8'h00);
    chk("R9 cleared", {63'h0, en_load}, 64'h0);

    // R11: extra bytes after eighth
    for (int i = 0; i < 10; i++) send(8'hA0 + 8'(i));
    chk("R11 first byte", {56'h0, sp_data[7:0]}, 64'hA0);
    chk("R11 last byte", {56'h0, sp_data[63:56]}, 64'hA7);
    rd();
    brst(1);
    chk("R5 no pf after full", {56'h0, es_byte[5]}, 64'h0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule